// File: doc/BRIEF.md
# Receive Event Statistics Counters

This block holds three 16-bit event counters for a 10/100 Ethernet physical layer. A management agent reads them. The first counter records link disconnect events. The second records false-carrier events, where carrier rose without a valid start delimiter. The third records received packets that carried at least one receive error. The upstream detectors supply single-cycle event pulses and per-packet framing signals: carrier, receive error, collision and end of packet.

The counters follow different overflow rules. The disconnect counter rolls over to zero. The false-carrier counter and the packet-error counter stop at all-ones. Receive errors and collisions are collected in sticky flags for the whole packet. The packet-error counter is updated once, in the cycle that follows the end-of-packet marker. Each counter has its own clear strobe, which the management side asserts after a read.

Top module: `phy_evt_stats`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets all three counters to zero. It also discards any receive error or collision already collected for the packet in progress.
- R2: Each cycle with `disc_evt` high adds one to `disc_cnt`, visible after that clock edge.
- R3: When `disc_cnt` is 16'hFFFF, one more disconnect event makes it 16'h0000.
- R4: Each cycle with `fc_evt` high adds one to `fc_cnt`.
- R5: When `fc_cnt` is 16'hFFFF, further false-carrier events leave it at 16'hFFFF.
- R6: `rxe_cnt` rises by exactly one per packet in which `rx_err` was high in at least one cycle with `rx_crs` high, however many error cycles the packet had. An error in the end-of-packet cycle itself counts. The update appears only after the edge that samples `rx_eop` high, and not when the error is seen.
- R7: A packet in which `rx_col` was high (with `rx_crs` high) in any cycle up to and including its end-of-packet cycle does not change `rxe_cnt`. The collected error and collision state is cleared at end of packet, so it does not carry into the next packet.
- R8: A clear strobe (`clr_disc`, `clr_fc`, `clr_rxe`) sets its counter to zero. If that counter's increment condition holds in the same cycle, the counter becomes one instead. This holds even when the counter was saturated.
- R9: A packet with no receive error leaves `rxe_cnt` unchanged.
- R10: `rx_err` and `rx_col` are ignored in cycles where `rx_crs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| disc_evt | input | 1 | Disconnect event pulse |
| fc_evt | input | 1 | False-carrier event pulse |
| rx_crs | input | 1 | Carrier present / packet in progress |
| rx_err | input | 1 | Receive error condition this cycle |
| rx_col | input | 1 | Collision seen this cycle |
| rx_eop | input | 1 | Last cycle of the current packet |
| clr_disc | input | 1 | Clear strobe for the disconnect counter |
| clr_fc | input | 1 | Clear strobe for the false-carrier counter |
| clr_rxe | input | 1 | Clear strobe for the packet-error counter |
| disc_cnt | output | 16 | Disconnect count |
| fc_cnt | output | 16 | False-carrier count |
| rxe_cnt | output | 16 | Count of errored, collision-free packets |

## Verification
The assertions check several rules on every cycle. They cover single-step increments, wrap at the top of the disconnect counter and hold at the top of the false-carrier counter. They also cover the clear-to-zero and clear-to-one outcomes, the packet-error counter staying still outside end-of-packet cycles and in collided packets, and the reset outcome. Only the bench's scenarios can show the per-packet rules. These include a multi-error packet counting once, an error in the end-of-packet cycle counting, and flags being dropped by reset or after a collided packet. Signals outside carrier having no effect also needs a scenario, as does the long run that drives both counters to their limits.

// File: rtl/phy_evt_stats_pkg.sv
package phy_evt_stats_pkg;
    // per-packet sticky state collected between end-of-packet markers
    typedef struct packed {
        logic err;
        logic col;
    } pkt_flags_t;
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
    parameter int W   = 16,
    parameter bit SAT = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] value
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    localparam logic [W-1:0] ONE = W'(1);

    cnt_state_t st_d, st_q;
    logic [W-1:0] bumped;

    generate
        if (SAT) begin : g_hold
            assign bumped = (&st_q.cnt) ? st_q.cnt : st_q.cnt + ONE;
        end else begin : g_roll
            assign bumped = st_q.cnt + ONE;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = inc ? ONE : '0;
        end else if (inc) begin
            st_d.cnt = bumped;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.cnt;
endmodule

// File: rtl/pkt_err_tracker.sv
module pkt_err_tracker
    import phy_evt_stats_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rx_crs,
    input  logic rx_err,
    input  logic rx_col,
    input  logic rx_eop,
    output logic bad_pkt
);
    pkt_flags_t fl_d, fl_q;
    logic seen_err, seen_col;

    always_comb begin
        seen_err = fl_q.err | (rx_crs & rx_err);
        seen_col = fl_q.col | (rx_crs & rx_col);
        bad_pkt  = rx_eop & seen_err & ~seen_col;
        fl_d.err = rx_eop ? 1'b0 : seen_err;
        fl_d.col = rx_eop ? 1'b0 : seen_col;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end
endmodule

// File: rtl/phy_evt_stats.sv
module phy_evt_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             disc_evt,
    input  logic             fc_evt,
    input  logic             rx_crs,
    input  logic             rx_err,
    input  logic             rx_col,
    input  logic             rx_eop,
    input  logic             clr_disc,
    input  logic             clr_fc,
    input  logic             clr_rxe,
    output logic [CNT_W-1:0] disc_cnt,
    output logic [CNT_W-1:0] fc_cnt,
    output logic [CNT_W-1:0] rxe_cnt
);
    logic bad_pkt;

    pkt_err_tracker u_trk (
        .clk    (clk),
        .rst    (rst),
        .rx_crs (rx_crs),
        .rx_err (rx_err),
        .rx_col (rx_col),
        .rx_eop (rx_eop),
        .bad_pkt(bad_pkt)
    );

    stat_counter #(.W(CNT_W), .SAT(1'b0)) u_disc (
        .clk(clk), .rst(rst), .inc(disc_evt), .clr(clr_disc), .value(disc_cnt)
    );

    stat_counter #(.W(CNT_W), .SAT(1'b1)) u_fc (
        .clk(clk), .rst(rst), .inc(fc_evt), .clr(clr_fc), .value(fc_cnt)
    );

    stat_counter #(.W(CNT_W), .SAT(1'b1)) u_rxe (
        .clk(clk), .rst(rst), .inc(bad_pkt), .clr(clr_rxe), .value(rxe_cnt)
    );
endmodule

// File: rtl/phy_evt_stats_chk.sv
module phy_evt_stats_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             disc_evt,
    input logic             fc_evt,
    input logic             rx_crs,
    input logic             rx_col,
    input logic             rx_eop,
    input logic             clr_disc,
    input logic             clr_fc,
    input logic             clr_rxe,
    input logic [CNT_W-1:0] disc_cnt,
    input logic [CNT_W-1:0] fc_cnt,
    input logic [CNT_W-1:0] rxe_cnt
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (disc_cnt == '0 && fc_cnt == '0 && rxe_cnt == '0));

    // R2
    disc_step_chk: assert property (@(posedge clk) disable iff (rst)
        disc_evt && !clr_disc && disc_cnt != TOP |=> disc_cnt == $past(disc_cnt) + ONE);

    // R3
    disc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        disc_evt && !clr_disc && disc_cnt == TOP |=> disc_cnt == '0);

    // R4
    fc_step_chk: assert property (@(posedge clk) disable iff (rst)
        fc_evt && !clr_fc && fc_cnt != TOP |=> fc_cnt == $past(fc_cnt) + ONE);

    // R5
    fc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_fc && fc_cnt == TOP |=> fc_cnt == TOP);

    // R6
    rxe_eop_only_chk: assert property (@(posedge clk) disable iff (rst)
        !rx_eop && !clr_rxe |=> $stable(rxe_cnt));

    // R7
    rxe_col_skip_chk: assert property (@(posedge clk) disable iff (rst)
        rx_eop && rx_crs && rx_col && !clr_rxe |=> $stable(rxe_cnt));

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_disc && !disc_evt |=> disc_cnt == '0);

    // R8
    clr_one_chk: assert property (@(posedge clk) disable iff (rst)
        clr_fc && fc_evt |=> fc_cnt == ONE);
endmodule

bind phy_evt_stats phy_evt_stats_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .disc_evt(disc_evt), .fc_evt(fc_evt),
    .rx_crs(rx_crs), .rx_col(rx_col), .rx_eop(rx_eop),
    .clr_disc(clr_disc), .clr_fc(clr_fc), .clr_rxe(clr_rxe),
    .disc_cnt(disc_cnt), .fc_cnt(fc_cnt), .rxe_cnt(rxe_cnt)
);

// File: tb/phy_evt_stats_bench.sv
module phy_evt_stats_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic disc_evt = 0, fc_evt = 0, rx_crs = 0, rx_err = 0, rx_col = 0, rx_eop = 0;
    logic clr_disc = 0, clr_fc = 0, clr_rxe = 0;
    logic [15:0] disc_cnt, fc_cnt, rxe_cnt;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    phy_evt_stats u_phy_evt_stats (.*);

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // one packet of len cycles; err/col high in cycle index errat/colat (-1 none)
    task automatic packet(int len, int errat, int colat);
        for (int i = 0; i < len; i++) begin
            rx_crs = 1; rx_err = (i == errat); rx_col = (i == colat);
            rx_eop = (i == len - 1);
            cyc();
        end
        rx_crs = 0; rx_err = 0; rx_col = 0; rx_eop = 0;
    endtask

    task automatic t_reset();
        rst = 1; cyc(); cyc();
        rst = 0; cyc();
        chk("R1 disc", disc_cnt, 0); chk("R1 fc", fc_cnt, 0); chk("R1 rxe", rxe_cnt, 0);
        rx_crs = 1; rx_err = 1; cyc();
        rx_err = 0; rst = 1; cyc();
        rst = 0; rx_eop = 1; cyc();
        rx_crs = 0; rx_eop = 0; cyc();
        chk("R1 flags dropped", rxe_cnt, 0);
    endtask

    task automatic t_disc();
        disc_evt = 1; cyc();
        chk("R2 first", disc_cnt, 1);
        cyc(); disc_evt = 0; cyc(); cyc();
        chk("R2 idle", disc_cnt, 2);
        disc_evt = 1; cyc(); disc_evt = 0;
        chk("R2 third", disc_cnt, 3);
    endtask

    task automatic t_fc();
        fc_evt = 1; cyc(); fc_evt = 0; cyc(); fc_evt = 1; cyc(); fc_evt = 0;
        chk("R4 two", fc_cnt, 2);
    endtask

    task automatic t_rxe();
        for (int i = 0; i < 3; i++) begin
            rx_crs = 1; rx_err = (i == 1); cyc();
        end
        rx_err = 0;
        chk("R6 not before eop", rxe_cnt, 0);
        rx_eop = 1; cyc(); rx_eop = 0; rx_crs = 0;
        chk("R6 at eop", rxe_cnt, 1);
        for (int i = 0; i < 4; i++) begin
            rx_crs = 1; rx_err = 1; rx_eop = (i == 3); cyc();
        end
        rx_crs = 0; rx_err = 0; rx_eop = 0;
        chk("R6 once per packet", rxe_cnt, 2);
        packet(4, 3, -1);
        chk("R6 err in eop cycle", rxe_cnt, 3);
        packet(5, -1, -1);
        chk("R9 clean packet", rxe_cnt, 3);
        rx_err = 1; rx_col = 0; cyc(); rx_err = 0; cyc();
        packet(3, -1, -1);
        chk("R10 err outside carrier", rxe_cnt, 3);
        rx_col = 1; cyc(); rx_col = 0;
        packet(3, 1, -1);
        chk("R10 col outside carrier", rxe_cnt, 4);
    endtask

    task automatic t_col();
        packet(5, 1, 3);
        chk("R7 collided", rxe_cnt, 4);
        packet(3, -1, 2);
        chk("R7 col in eop", rxe_cnt, 4);
        packet(3, -1, -1);
        chk("R7 flags cleared", rxe_cnt, 4);
        packet(3, 0, -1);
        chk("R7 next counts", rxe_cnt, 5);
    endtask

    task automatic t_clear();
        clr_disc = 1; cyc(); clr_disc = 0;
        chk("R8 clr disc", disc_cnt, 0);
        clr_fc = 1; fc_evt = 1; cyc(); clr_fc = 0; fc_evt = 0;
        chk("R8 clr fc with evt", fc_cnt, 1);
        rx_crs = 1; rx_err = 1; rx_eop = 1; clr_rxe = 1; cyc();
        rx_crs = 0; rx_err = 0; rx_eop = 0; clr_rxe = 0;
        chk("R8 clr rxe with pkt", rxe_cnt, 1);
    endtask

    task automatic t_limits();
        clr_disc = 1; clr_fc = 1; cyc(); clr_disc = 0; clr_fc = 0;
        disc_evt = 1; fc_evt = 1;
        for (int i = 0; i < 65535; i++) cyc();
        chk("R2 reach top", disc_cnt, 16'hFFFF);
        chk("R4 reach top", fc_cnt, 16'hFFFF);
        cyc();
        chk("R3 wrap", disc_cnt, 16'h0000);
        chk("R5 hold", fc_cnt, 16'hFFFF);
        cyc(); cyc(); disc_evt = 0;
        chk("R5 still hold", fc_cnt, 16'hFFFF);
        fc_evt = 0; clr_fc = 1; cyc(); clr_fc = 0;
        chk("R8 clr saturated", fc_cnt, 0);
    endtask

    initial begin
        cyc();
        t_reset();
        t_disc();
        t_fc();
        t_rxe();
        t_col();
        t_clear();
        t_limits();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule